// File: doc/BRIEF.md
# Field-Typed Control and Status Register Bank

This block is a small bank of 32-bit control and status registers reached through an AXI4-Lite slave port. Each register holds one field starting at bit 0. Each field has one access behaviour. A status field shows a live hardware input. A control field is stored by software and drives an output. A mode field is written by software to drive an output, but reads back a separate hardware input. An event field captures hardware events as sticky bits that software clears by writing ones. A pulse field turns a written one into a strobe that lasts one clock.

Hardware logic connects to the field ports. Software uses the bus. The event and pulse fields each have an external clear input that forces the field to zero and takes priority over every other source. Writes honour the byte strobes. The write address and write data channels are accepted independently and in any order. Every response is OKAY.

Top module: `field_regbank`

## Requirements
- R1: Register `i` sits at byte address `4*i`: status at 0x00, control at 0x04, mode at 0x08, event at 0x0C and pulse at 0x10. Address bits [1:0] are ignored. Indices 5 to 7 read as zero, and writes to them change nothing.
- R2: A read of the status register returns `stat_in` in bits [15:0] with zeros above. A write to it has no effect.
- R3: A write to the control register is stored and drives `ctrl_out` from the clock edge after the write is performed. A read returns the stored value.
- R4: A write to the mode register drives `mode_out` with bits [11:0]. A read returns `mode_in` in bits [11:0] with zeros above.
- R5: Any `evt_set` bit that is high for even one clock sets the matching event bit. The bit reads as 1 until software writes 1 to that bit position of register 0x0C. Writing 0 leaves it set.
- R6: When a hardware set and a software write-one-to-clear hit the same event bit in the same cycle, the bit stays set.
- R7: Writing 1 to a bit of register 0x10 raises that bit of `pls_out` for exactly one clock, starting at the edge after the write is performed. A read of 0x10 returns zero.
- R8: While `evt_clr` is high, all event bits are forced to zero, even against `evt_set`. While `pls_clr` is high, no pulse bit is raised.
- R9: Only the byte lanes enabled in `s_wstrb` are updated. Strobe bit `k` covers data bits [8k+7:8k].
- R10: AW and W are accepted independently in either order. `s_bresp` and `s_rresp` are 2'b00. `s_bvalid` stays high until `s_bready` is high. `s_rvalid` and `s_rdata` stay unchanged until `s_rready` is high. Read data is taken at the AR handshake.
- R11: While `aresetn` is low, every stored bit clears: `ctrl_out`, `mode_out`, `evt_flags`, `pls_out` and both responses go to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Clock |
| aresetn | input | 1 | Active-low asynchronous reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | 5 | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | 5 | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| stat_in | input | 16 | Live status value |
| ctrl_out | output | 32 | Stored control value |
| mode_out | output | 12 | Software-written mode value |
| mode_in | input | 12 | Mode value returned on reads |
| evt_set | input | 8 | Event capture inputs |
| evt_clr | input | 1 | Forces all event bits to zero |
| evt_flags | output | 8 | Current sticky event bits |
| pls_out | output | 4 | One-clock strobes |
| pls_clr | input | 1 | Suppresses pulse bits |

## Verification
Two functions can fall in the same cycle: a software write-one-to-clear of an event bit and a hardware set of that same bit. The bench raises `evt_set` exactly in the cycle where both write channels are held and the write is performed. It expects the bit to read back as 1, and in a separate run without the collision it expects the bit to clear. A second collision sets the event field and asserts the external clear in the same cycle, and the field is expected to read as zero. A reference model in the bench checks every output on every clock.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
   localparam int DATA_W    = 32;
   localparam int STRB_W    = DATA_W / 8;
   localparam int ADDR_STEP = DATA_W / 8;
   localparam logic [1:0] RESP_OKAY = 2'b00;

   typedef enum logic [1:0] {
      FK_RW    = 2'd0,
      FK_SPLIT = 2'd1,
      FK_W1C   = 2'd2,
      FK_PULSE = 2'd3
   } field_kind_e;

   function automatic logic [DATA_W-1:0] strb_to_mask(input logic [STRB_W-1:0] s);
      logic [DATA_W-1:0] m;
      for (int i = 0; i < STRB_W; i++) m[8*i +: 8] = {8{s[i]}};
      return m;
   endfunction
endpackage

// File: rtl/regbank_axil.sv
module regbank_axil
   import regbank_pkg::*;
#(
   parameter int ADDR_W = 5,
   localparam int LSB   = $clog2(ADDR_STEP),
   localparam int IDX_W = ADDR_W - LSB
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              awvalid,
   output logic              awready,
   input  logic [ADDR_W-1:0] awaddr,
   input  logic              wvalid,
   output logic              wready,
   input  logic [DATA_W-1:0] wdata,
   input  logic [STRB_W-1:0] wstrb,
   output logic              bvalid,
   input  logic              bready,
   output logic [1:0]        bresp,
   input  logic              arvalid,
   output logic              arready,
   input  logic [ADDR_W-1:0] araddr,
   output logic              rvalid,
   input  logic              rready,
   output logic [DATA_W-1:0] rdata,
   output logic [1:0]        rresp,
   output logic              wr_fire,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [DATA_W-1:0] wr_data,
   output logic [STRB_W-1:0] wr_strb,
   output logic [IDX_W-1:0]  rd_idx,
   input  logic [DATA_W-1:0] rd_word
);
   if (ADDR_W <= LSB) begin : g_addr_bad
      $error("ADDR_W too small for a word index");
   end

   logic aw_held, w_held;

   assign awready = !aw_held && !bvalid;
   assign wready  = !w_held && !bvalid;
   assign arready = !rvalid;
   assign wr_fire = aw_held && w_held && !bvalid;
   assign rd_idx  = araddr[ADDR_W-1:LSB];
   assign bresp   = RESP_OKAY;
   assign rresp   = RESP_OKAY;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aw_held <= 1'b0;
         w_held  <= 1'b0;
         wr_idx  <= '0;
         wr_data <= '0;
         wr_strb <= '0;
         bvalid  <= 1'b0;
         rvalid  <= 1'b0;
         rdata   <= '0;
      end else begin
         if (awvalid && awready) begin
            aw_held <= 1'b1;
            wr_idx  <= awaddr[ADDR_W-1:LSB];
         end else if (wr_fire) begin
            aw_held <= 1'b0;
         end
         if (wvalid && wready) begin
            w_held  <= 1'b1;
            wr_data <= wdata;
            wr_strb <= wstrb;
         end else if (wr_fire) begin
            w_held <= 1'b0;
         end
         if (wr_fire)     bvalid <= 1'b1;
         else if (bready) bvalid <= 1'b0;
         if (arvalid && arready) begin
            rvalid <= 1'b1;
            rdata  <= rd_word;
         end else if (rready) begin
            rvalid <= 1'b0;
         end
      end
   end

   // R10
   b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bvalid && !bready) |=> bvalid);
   // R10
   r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rvalid && !rready) |=> (rvalid && $stable(rdata)));
   // R10
   one_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire |=> !wr_fire);
endmodule

// File: rtl/regbank_field.sv
module regbank_field
   import regbank_pkg::*;
#(
   parameter int          W    = 8,
   parameter field_kind_e KIND = FK_RW
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] wmask,
   input  logic [W-1:0] hw_in,
   input  logic         hw_clr,
   output logic [W-1:0] hw_out,
   output logic [W-1:0] rd_val
);
   if (W < 1 || W > DATA_W) begin : g_w_bad
      $error("field width out of range");
   end

   logic [W-1:0] q, q_nxt, hit, lanes;

   assign lanes = wmask & {W{wr_en}};
   assign hit   = wdata & lanes;

   always_comb begin
      if (KIND == FK_W1C)        q_nxt = (q & ~hit) | hw_in;
      else if (KIND == FK_PULSE) q_nxt = hit;
      else                       q_nxt = (q & ~lanes) | hit;
      if (hw_clr) q_nxt = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= q_nxt;
   end

   assign hw_out = q;

   if (KIND == FK_SPLIT) begin : g_rd_split
      assign rd_val = hw_in;
   end else if (KIND == FK_PULSE) begin : g_rd_pulse
      assign rd_val = '0;
   end else begin : g_rd_store
      assign rd_val = q;
   end

   if (KIND == FK_W1C) begin : g_w1c_chk
      // R6
      set_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (|hw_in && !hw_clr) |=> ((q & $past(hw_in)) == $past(hw_in)));
   end
   if (KIND == FK_RW || KIND == FK_SPLIT) begin : g_lane_chk
      // R9
      lane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && !hw_clr) |=> (((q ^ $past(q)) & ~$past(wmask)) == '0));
   end
   if (KIND == FK_PULSE) begin : g_pulse_chk
      // R7
      pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (|q && !wr_en) |=> (q == '0));
   end
endmodule

// File: rtl/field_regbank.sv
module field_regbank
   import regbank_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int STAT_W = 16,
   parameter int CTRL_W = 32,
   parameter int MODE_W = 12,
   parameter int EVT_W  = 8,
   parameter int PLS_W  = 4
)(
   input  logic              aclk,
   input  logic              aresetn,
   input  logic              s_awvalid,
   output logic              s_awready,
   input  logic [ADDR_W-1:0] s_awaddr,
   input  logic              s_wvalid,
   output logic              s_wready,
   input  logic [DATA_W-1:0] s_wdata,
   input  logic [STRB_W-1:0] s_wstrb,
   output logic              s_bvalid,
   input  logic              s_bready,
   output logic [1:0]        s_bresp,
   input  logic              s_arvalid,
   output logic              s_arready,
   input  logic [ADDR_W-1:0] s_araddr,
   output logic              s_rvalid,
   input  logic              s_rready,
   output logic [DATA_W-1:0] s_rdata,
   output logic [1:0]        s_rresp,
   input  logic [STAT_W-1:0] stat_in,
   output logic [CTRL_W-1:0] ctrl_out,
   output logic [MODE_W-1:0] mode_out,
   input  logic [MODE_W-1:0] mode_in,
   input  logic [EVT_W-1:0]  evt_set,
   input  logic              evt_clr,
   output logic [EVT_W-1:0]  evt_flags,
   output logic [PLS_W-1:0]  pls_out,
   input  logic              pls_clr
);
   localparam int NUM_REGS = 5;
   localparam int IDX_W    = ADDR_W - $clog2(ADDR_STEP);
   localparam logic [IDX_W-1:0] IX_STAT = IDX_W'(0);
   localparam logic [IDX_W-1:0] IX_CTRL = IDX_W'(1);
   localparam logic [IDX_W-1:0] IX_MODE = IDX_W'(2);
   localparam logic [IDX_W-1:0] IX_EVT  = IDX_W'(3);
   localparam logic [IDX_W-1:0] IX_PLS  = IDX_W'(4);

   if ((1 << IDX_W) < NUM_REGS) begin : g_map_bad
      $error("address width cannot reach every register");
   end
   if (STAT_W > DATA_W || CTRL_W > DATA_W || MODE_W > DATA_W ||
       EVT_W > DATA_W || PLS_W > DATA_W) begin : g_width_bad
      $error("a field is wider than the data bus");
   end

   logic              wr_fire;
   logic [IDX_W-1:0]  wr_idx, rd_idx;
   logic [DATA_W-1:0] wr_data, wr_mask, rd_word;
   logic [STRB_W-1:0] wr_strb;
   logic [CTRL_W-1:0] ctrl_rd;
   logic [MODE_W-1:0] mode_rd;
   logic [EVT_W-1:0]  evt_rd;
   logic [PLS_W-1:0]  pls_rd;

   regbank_axil #(.ADDR_W(ADDR_W)) u_bus (
      .clk(aclk), .rst_n(aresetn),
      .awvalid(s_awvalid), .awready(s_awready), .awaddr(s_awaddr),
      .wvalid(s_wvalid), .wready(s_wready), .wdata(s_wdata), .wstrb(s_wstrb),
      .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp),
      .arvalid(s_arvalid), .arready(s_arready), .araddr(s_araddr),
      .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata), .rresp(s_rresp),
      .wr_fire(wr_fire), .wr_idx(wr_idx), .wr_data(wr_data), .wr_strb(wr_strb),
      .rd_idx(rd_idx), .rd_word(rd_word)
   );

   assign wr_mask = strb_to_mask(wr_strb);

   regbank_field #(.W(CTRL_W), .KIND(FK_RW)) u_ctrl (
      .clk(aclk), .rst_n(aresetn), .wr_en(wr_fire && wr_idx == IX_CTRL),
      .wdata(wr_data[CTRL_W-1:0]), .wmask(wr_mask[CTRL_W-1:0]),
      .hw_in('0), .hw_clr(1'b0), .hw_out(ctrl_out), .rd_val(ctrl_rd)
   );

   regbank_field #(.W(MODE_W), .KIND(FK_SPLIT)) u_mode (
      .clk(aclk), .rst_n(aresetn), .wr_en(wr_fire && wr_idx == IX_MODE),
      .wdata(wr_data[MODE_W-1:0]), .wmask(wr_mask[MODE_W-1:0]),
      .hw_in(mode_in), .hw_clr(1'b0), .hw_out(mode_out), .rd_val(mode_rd)
   );

   regbank_field #(.W(EVT_W), .KIND(FK_W1C)) u_evt (
      .clk(aclk), .rst_n(aresetn), .wr_en(wr_fire && wr_idx == IX_EVT),
      .wdata(wr_data[EVT_W-1:0]), .wmask(wr_mask[EVT_W-1:0]),
      .hw_in(evt_set), .hw_clr(evt_clr), .hw_out(evt_flags), .rd_val(evt_rd)
   );

   regbank_field #(.W(PLS_W), .KIND(FK_PULSE)) u_pls (
      .clk(aclk), .rst_n(aresetn), .wr_en(wr_fire && wr_idx == IX_PLS),
      .wdata(wr_data[PLS_W-1:0]), .wmask(wr_mask[PLS_W-1:0]),
      .hw_in('0), .hw_clr(pls_clr), .hw_out(pls_out), .rd_val(pls_rd)
   );

   always_comb begin
      rd_word = '0;
      case (rd_idx)
         IX_STAT: rd_word[STAT_W-1:0] = stat_in;
         IX_CTRL: rd_word[CTRL_W-1:0] = ctrl_rd;
         IX_MODE: rd_word[MODE_W-1:0] = mode_rd;
         IX_EVT:  rd_word[EVT_W-1:0]  = evt_rd;
         IX_PLS:  rd_word[PLS_W-1:0]  = pls_rd;
         default: rd_word = '0;
      endcase
   end

   // R8
   evt_clear_chk: assert property (@(posedge aclk) disable iff (!aresetn)
      evt_clr |=> (evt_flags == '0));
   // R7
   pls_source_chk: assert property (@(posedge aclk) disable iff (!aresetn)
      (|pls_out) |-> $past(wr_fire && wr_idx == IX_PLS));
   // R11
   reset_state_chk: assert property (@(posedge aclk) disable iff (!aresetn)
      $rose(aresetn) |-> (ctrl_out == '0 && mode_out == '0 &&
                          evt_flags == '0 && pls_out == '0));
endmodule

// File: tb/sim_field_regbank.sv
`timescale 1ns/1ps
module sim_field_regbank;
   logic        aclk = 1'b0;
   logic        aresetn = 1'b0;
   logic        s_awvalid = 1'b0, s_wvalid = 1'b0, s_arvalid = 1'b0;
   logic        s_bready = 1'b1, s_rready = 1'b1;
   logic [4:0]  s_awaddr = '0, s_araddr = '0;
   logic [31:0] s_wdata = '0;
   logic [3:0]  s_wstrb = '0;
   logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
   logic [1:0]  s_bresp, s_rresp;
   logic [31:0] s_rdata;
   logic [15:0] stat_in = 16'h0000;
   logic [31:0] ctrl_out;
   logic [11:0] mode_out;
   logic [11:0] mode_in = 12'h000;
   logic [7:0]  evt_set = '0, evt_flags;
   logic        evt_clr = 1'b0, pls_clr = 1'b0;
   logic [3:0]  pls_out;

   int n_chk = 0, n_fail = 0;
   bit started = 0;

   always #2 aclk = ~aclk;

   field_regbank u0 (
      .aclk(aclk), .aresetn(aresetn),
      .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
      .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
      .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
      .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
      .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
      .stat_in(stat_in), .ctrl_out(ctrl_out), .mode_out(mode_out), .mode_in(mode_in),
      .evt_set(evt_set), .evt_clr(evt_clr), .evt_flags(evt_flags),
      .pls_out(pls_out), .pls_clr(pls_clr)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // behavioural reference model, advanced on each rising edge
   bit          m_awh, m_wh, m_bv, m_rv;
   logic [2:0]  m_aw_ix;
   logic [31:0] m_wd, m_rd, m_ctrl;
   logic [3:0]  m_strb;
   logic [11:0] m_mode;
   logic [7:0]  m_evt;
   logic [3:0]  m_pls;

   function automatic logic [31:0] model_read(input logic [4:0] a);
      case (a[4:2])
         3'd0:    return {16'h0, stat_in};
         3'd1:    return m_ctrl;
         3'd2:    return {20'h0, mode_in};
         3'd3:    return {24'h0, m_evt};
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge aclk) begin
      started = 1;
      if (!aresetn) begin
         m_awh = 0; m_wh = 0; m_bv = 0; m_rv = 0; m_rd = '0; m_aw_ix = '0;
         m_wd = '0; m_strb = '0; m_ctrl = '0; m_mode = '0; m_evt = '0; m_pls = '0;
      end else begin
         bit fire, aw_rdy, w_rdy;
         logic [31:0] msk, hitv;
         fire   = m_awh && m_wh && !m_bv;
         aw_rdy = !m_awh && !m_bv;
         w_rdy  = !m_wh && !m_bv;
         if (s_arvalid && !m_rv) begin m_rd = model_read(s_araddr); m_rv = 1; end
         else if (s_rready) m_rv = 0;
         for (int b = 0; b < 4; b++) msk[8*b +: 8] = {8{m_strb[b]}};
         hitv = fire ? (m_wd & msk) : 32'h0;
         if (fire && m_aw_ix == 3'd1) m_ctrl = (m_ctrl & ~msk) | hitv;
         if (fire && m_aw_ix == 3'd2) m_mode = (m_mode & ~msk[11:0]) | hitv[11:0];
         if (evt_clr) m_evt = '0;
         else m_evt = (m_evt & ~((fire && m_aw_ix == 3'd3) ? hitv[7:0] : 8'h0)) | evt_set;
         m_pls = (pls_clr || !(fire && m_aw_ix == 3'd4)) ? 4'h0 : hitv[3:0];
         if (fire) m_bv = 1; else if (s_bready) m_bv = 0;
         if (s_awvalid && aw_rdy) begin m_awh = 1; m_aw_ix = s_awaddr[4:2]; end
         else if (fire) m_awh = 0;
         if (s_wvalid && w_rdy) begin m_wh = 1; m_wd = s_wdata; m_strb = s_wstrb; end
         else if (fire) m_wh = 0;
      end
   end

   always @(negedge aclk) begin
      if (started && aresetn) begin
         check("R10 awready", 32'(s_awready), 32'(!m_awh && !m_bv));
         check("R10 wready",  32'(s_wready),  32'(!m_wh && !m_bv));
         check("R10 bvalid",  32'(s_bvalid),  32'(m_bv));
         check("R10 arready", 32'(s_arready), 32'(!m_rv));
         check("R10 rvalid",  32'(s_rvalid),  32'(m_rv));
         if (s_bvalid) check("R10 bresp", 32'(s_bresp), 32'h0);
         if (s_rvalid) begin
            check("R10 rresp", 32'(s_rresp), 32'h0);
            check("R1 rdata",  s_rdata, m_rd);
         end
         check("R3 ctrl_out",  ctrl_out, m_ctrl);
         check("R4 mode_out",  32'(mode_out), 32'(m_mode));
         check("R5 evt_flags", 32'(evt_flags), 32'(m_evt));
         check("R7 pls_out",   32'(pls_out), 32'(m_pls));
      end
   end

   task automatic axi_write(input logic [4:0] a, input logic [31:0] d, input logic [3:0] st,
                            input int awd, input int wd, input logic [7:0] fset);
      bit aw_ok = 0, w_ok = 0;
      int n = 0;
      while (!(aw_ok && w_ok)) begin
         s_awvalid = !aw_ok && n >= awd; s_awaddr = a;
         s_wvalid  = !w_ok && n >= wd;   s_wdata = d; s_wstrb = st;
         #1;
         if (s_awvalid && s_awready) aw_ok = 1;
         if (s_wvalid && s_wready)   w_ok = 1;
         @(negedge aclk);
         n++;
      end
      s_awvalid = 0; s_wvalid = 0;
      evt_set = fset;
      @(negedge aclk);
      evt_set = '0;
   endtask

   task automatic axi_read(input logic [4:0] a, output logic [31:0] d);
      bit ok = 0;
      while (!ok) begin
         s_arvalid = 1; s_araddr = a;
         #1;
         if (s_arready) ok = 1;
         @(negedge aclk);
      end
      s_arvalid = 0;
      d = s_rdata;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge aclk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] rd, held;
      repeat (5) @(negedge aclk);
      aresetn = 1;
      @(negedge aclk);
      // R11 reset state
      check("R11 ctrl_out reset",  ctrl_out, 32'h0);
      check("R11 evt_flags reset", 32'(evt_flags), 32'h0);
      check("R11 pls_out reset",   32'(pls_out), 32'h0);
      check("R11 mode_out reset",  32'(mode_out), 32'h0);

      // R2 status read and ignored write
      stat_in = 16'hBEEF;
      axi_read(5'h00, rd);  check("R2 status read", rd, 32'h0000BEEF);
      axi_write(5'h00, 32'hFFFFFFFF, 4'hF, 0, 0, 8'h0);
      axi_read(5'h00, rd);  check("R2 status write ignored", rd, 32'h0000BEEF);

      // R3 control, AW before W and W before AW (R10)
      axi_write(5'h04, 32'hA5A51234, 4'hF, 0, 3, 8'h0);
      check("R3 ctrl_out after write", ctrl_out, 32'hA5A51234);
      axi_read(5'h04, rd);  check("R3 control readback", rd, 32'hA5A51234);
      // R9 lanes 0 and 2 only
      axi_write(5'h04, 32'hFFFFFFFF, 4'b0101, 4, 0, 8'h0);
      check("R9 strobe lanes", ctrl_out, 32'hA5FF12FF);
      // R1 low address bits ignored
      axi_read(5'h06, rd);  check("R1 low bits ignored", rd, 32'hA5FF12FF);

      // R4 mode split
      mode_in = 12'h321;
      axi_write(5'h08, 32'h00000ABC, 4'hF, 0, 0, 8'h0);
      check("R4 mode_out", 32'(mode_out), 32'h00000ABC);
      axi_read(5'h08, rd);  check("R4 mode read returns input", rd, 32'h00000321);

      // R5 sticky events
      evt_set = 8'h81; @(negedge aclk); evt_set = '0;
      axi_read(5'h0C, rd);  check("R5 event captured", rd, 32'h81);
      axi_write(5'h0C, 32'h01, 4'hF, 0, 0, 8'h0);
      axi_read(5'h0C, rd);  check("R5 write one clears", rd, 32'h80);
      axi_write(5'h0C, 32'h00, 4'hF, 0, 0, 8'h0);
      axi_read(5'h0C, rd);  check("R5 write zero keeps", rd, 32'h80);
      // R6 collision keeps bit set
      axi_write(5'h0C, 32'h80, 4'hF, 0, 0, 8'h80);
      axi_read(5'h0C, rd);  check("R6 set beats clear", rd, 32'h80);
      axi_write(5'h0C, 32'h80, 4'hF, 0, 0, 8'h00);
      axi_read(5'h0C, rd);  check("R6 clear without set", rd, 32'h00);
      // R8 external clear beats set
      evt_set = 8'h0F; @(negedge aclk);
      evt_set = 8'h30; evt_clr = 1; @(negedge aclk);
      evt_set = '0; evt_clr = 0;
      check("R8 evt_clr forces zero", 32'(evt_flags), 32'h0);

      // R7 pulse
      axi_write(5'h10, 32'h5, 4'hF, 0, 0, 8'h0);
      check("R7 pulse high", 32'(pls_out), 32'h5);
      @(negedge aclk);
      check("R7 pulse one clock", 32'(pls_out), 32'h0);
      axi_read(5'h10, rd);  check("R7 pulse reads zero", rd, 32'h0);
      // R8 pulse suppressed
      pls_clr = 1;
      axi_write(5'h10, 32'hF, 4'hF, 0, 0, 8'h0);
      check("R8 pls_clr suppresses", 32'(pls_out), 32'h0);
      pls_clr = 0;

      // R1 unmapped
      axi_write(5'h14, 32'h12345678, 4'hF, 0, 0, 8'h0);
      axi_read(5'h14, rd);  check("R1 unmapped 0x14", rd, 32'h0);
      axi_read(5'h1C, rd);  check("R1 unmapped 0x1C", rd, 32'h0);
      check("R1 unmapped write harmless", ctrl_out, 32'hA5FF12FF);

      // R10 response hold
      s_bready = 0;
      axi_write(5'h04, 32'h0000CAFE, 4'h3, 0, 0, 8'h0);
      repeat (2) @(negedge aclk);
      check("R10 bvalid held", 32'(s_bvalid), 32'h1);
      s_bready = 1; @(negedge aclk);
      check("R10 bvalid released", 32'(s_bvalid), 32'h0);
      s_rready = 0;
      axi_read(5'h04, held);
      repeat (2) @(negedge aclk);
      check("R10 rvalid held", 32'(s_rvalid), 32'h1);
      check("R10 rdata stable", s_rdata, held);
      check("R9 low lanes only", held, 32'hA5FFCAFE);
      s_rready = 1; @(negedge aclk);

      // R11 reset again
      aresetn = 0;
      repeat (2) @(negedge aclk);
      check("R11 ctrl_out cleared", ctrl_out, 32'h0);
      check("R11 mode_out cleared", 32'(mode_out), 32'h0);
      aresetn = 1;
      repeat (3) @(negedge aclk);
      finish_run();
   end
endmodule